// File: doc/BRIEF.md
# Die XOR Parity Rebuild Engine

This block protects a stripe of flash pages spread across several dies with one XOR parity page. Page beats arrive on a tagged stream, die by die in ascending order. The block folds each beat into a parity page buffer, so that after the last die of the stripe the buffer holds the bitwise XOR of every member page. Any beat of the parity page can be read through a side port.

When a die is reported bad, a rebuild request names it. The block records the die in a sticky failed map. It then asks for the surviving pages of the stripe in ascending die order, passing over the bad one. It XORs the survivors with the stored parity, which leaves the lost page, and streams that page out beat by beat toward a spare region. Each completed rebuild uses one spare slot. A request is refused with a status flag when two or more dies are marked failed, or when no spare slot remains. A refused request produces no output beats.

Top module: `xor_rebuild_engine`

## Requirements
- R1: After all NUM_DIES dies of a stripe (die 0 first, each PAGE_BEATS beats, beat 0 first) have been accepted, par_valid is 1 and par_rd_data for beat index b equals the XOR of beat b of every die in the stripe.
- R2: Accepting beat 0 of die 0 starts a new parity page, discarding the previous content, and drops par_valid to 0 in the following cycle.
- R3: Outside a rebuild, need_die names the next die of the stripe sequence. in_ready is 0 whenever in_die differs from need_die, and such a beat leaves the parity page and par_valid unchanged.
- R4: rb_ready is 1 only when no rebuild is in progress and par_valid is 1. A request held while par_valid is 0 changes neither failed_map nor the status flags.
- R5: During a rebuild, need_die steps through the surviving dies in ascending index order and never names the failed die. The first survivor is die 1 when die 0 has failed, and die 0 otherwise.
- R6: After the last survivor beat, the block presents the rebuilt page on out_data for beats 0 to PAGE_BEATS-1 in order, with out_beat giving the beat index and out_last marking the final beat. While out_ready is 0, out_valid, out_beat and out_data hold.
- R7: When the last rebuilt beat is taken, done becomes 1 and spare_left drops by exactly one.
- R8: An accepted rebuild request sets bit rb_die of failed_map, and bits are cleared only by reset.
- R9: If failed_map, with the requested die included, has two or more bits set, err_multi becomes 1, no beat is emitted, spare_left is unchanged, and the block stays ready for the write stream.
- R10: If exactly one die is failed but spare_left is 0, err_nospare becomes 1 and no beat is emitted.
- R11: After reset, par_valid, failed_map, done, err_multi, err_nospare and out_valid are 0, need_die is 0 and spare_left equals SPARE_SLOTS.
- R12: The three status flags hold until the next accepted request, which clears them. err_multi takes priority over err_nospare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Page beat offered |
| in_ready | output | 1 | Page beat accepted this cycle |
| in_die | input | DIE_W | Die that the offered beat belongs to |
| in_data | input | DATA_W | Page beat data |
| need_die | output | DIE_W | Die whose beats are expected next |
| rb_valid | input | 1 | Rebuild request |
| rb_ready | output | 1 | Rebuild request can be taken |
| rb_die | input | DIE_W | Die to be rebuilt |
| out_valid | output | 1 | Rebuilt beat available |
| out_ready | input | 1 | Rebuilt beat taken by the spare writer |
| out_data | output | DATA_W | Rebuilt beat data |
| out_beat | output | BEAT_W | Index of the rebuilt beat |
| out_last | output | 1 | Final beat of the rebuilt page |
| par_valid | output | 1 | Parity page complete for the current stripe |
| par_rd_beat | input | BEAT_W | Parity read beat index |
| par_rd_data | output | DATA_W | Parity beat at par_rd_beat |
| failed_map | output | NUM_DIES | Sticky map of failed dies |
| spare_left | output | SPARE_W | Spare slots remaining |
| done | output | 1 | Last rebuild completed |
| err_multi | output | 1 | Last request refused, two or more dies failed |
| err_nospare | output | 1 | Last request refused, no spare slot |

## Verification
The hardest states to reach from the ports are spare exhaustion and the case where both refusal conditions hold together. Each one is reached only after earlier rebuilds have completed in full and used up spare slots. The stimulus therefore runs two complete rebuilds of the same die, with a fresh stripe between them and stalls on the output side. It then repeats the request to reach the no-spare refusal, and names a second die while the slots are still empty, to show that the multi-failure flag wins. Separate reset phases rebuild die 0 and the highest die, which exercises both ends of the survivor ordering.

// File: rtl/xpr_pkg.sv
package xpr_pkg;
    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_GATHER = 2'd1,
        XS_EMIT   = 2'd2
    } xpr_state_e;
endpackage

// File: rtl/xpr_page_buf.sv
// One page of DATA_W words with a store-or-fold write port and N_RD
// combinational read ports.
module xpr_page_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int N_RD   = 1,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_xor,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [N_RD-1:0][AW-1:0]      rd_addr,
    output logic [N_RD-1:0][DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_xor ? (mem_q[wr_addr] ^ wr_data) : wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        assign rd_data[p] = mem_q[rd_addr[p]];
    end
endmodule

// File: rtl/xpr_fail_track.sv
// Sticky failed-die map and spare-slot counter.
module xpr_fail_track #(
    parameter int NUM_DIES    = 8,
    parameter int SPARE_SLOTS = 2,
    localparam int DIE_W      = $clog2(NUM_DIES),
    localparam int SPARE_W    = $clog2(SPARE_SLOTS + 1),
    localparam int CNT_W      = $clog2(NUM_DIES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mark_en,
    input  logic [DIE_W-1:0]    q_die,
    input  logic                use_en,
    output logic [NUM_DIES-1:0] failed,
    output logic [SPARE_W-1:0]  spare_left,
    output logic                multi_if,
    output logic                spare_empty
);
    logic [NUM_DIES-1:0] failed_q, failed_d, probe;
    logic [SPARE_W-1:0]  spare_q, spare_d;
    logic [CNT_W-1:0]    cnt;

    always_comb begin
        probe        = failed_q;
        probe[q_die] = 1'b1;
        cnt          = '0;
        for (int i = 0; i < NUM_DIES; i++) cnt = cnt + CNT_W'(probe[i]);
        multi_if     = (cnt >= CNT_W'(2));
        spare_empty  = (spare_q == '0);
        failed_d     = mark_en ? probe : failed_q;
        spare_d      = use_en ? (spare_q - SPARE_W'(1)) : spare_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            failed_q <= '0;
            spare_q  <= SPARE_W'(SPARE_SLOTS);
        end else begin
            failed_q <= failed_d;
            spare_q  <= spare_d;
        end
    end

    assign failed     = failed_q;
    assign spare_left = spare_q;

    // R8: a failed die stays failed until reset
    assert_failed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((failed_q & $past(failed_q)) == $past(failed_q)));

    // R10: a slot is never spent when none is left
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        use_en |-> (spare_q != '0));
endmodule

// File: rtl/xor_rebuild_engine.sv
module xor_rebuild_engine #(
    parameter int NUM_DIES    = 8,
    parameter int PAGE_BEATS  = 16,
    parameter int DATA_W      = 32,
    parameter int SPARE_SLOTS = 2,
    localparam int DIE_W      = $clog2(NUM_DIES),
    localparam int BEAT_W     = $clog2(PAGE_BEATS),
    localparam int SPARE_W    = $clog2(SPARE_SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DIE_W-1:0]    in_die,
    input  logic [DATA_W-1:0]   in_data,
    output logic [DIE_W-1:0]    need_die,
    input  logic                rb_valid,
    output logic                rb_ready,
    input  logic [DIE_W-1:0]    rb_die,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic [BEAT_W-1:0]   out_beat,
    output logic                out_last,
    output logic                par_valid,
    input  logic [BEAT_W-1:0]   par_rd_beat,
    output logic [DATA_W-1:0]   par_rd_data,
    output logic [NUM_DIES-1:0] failed_map,
    output logic [SPARE_W-1:0]  spare_left,
    output logic                done,
    output logic                err_multi,
    output logic                err_nospare
);
    import xpr_pkg::*;

    localparam logic [DIE_W:0]    DIE_END   = (DIE_W+1)'(NUM_DIES);
    localparam logic [DIE_W-1:0]  LAST_DIE  = DIE_W'(NUM_DIES - 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PAGE_BEATS - 1);

    typedef struct packed {
        xpr_state_e        st;
        logic [DIE_W-1:0]  wr_die;
        logic [BEAT_W-1:0] wr_beat;
        logic              par_valid;
        logic [DIE_W-1:0]  rb_die;
        logic [DIE_W-1:0]  cur_die;
        logic [BEAT_W-1:0] beat;
        logic              first;
        logic              done;
        logic              err_multi;
        logic              err_nospare;
    } regs_t;

    regs_t r_q, r_d;

    logic                         par_we, par_xor, acc_we, acc_xor;
    logic [DATA_W-1:0]            acc_wdata;
    logic [1:0][BEAT_W-1:0]       par_raddr;
    logic [1:0][DATA_W-1:0]       par_rdata;
    logic [0:0][BEAT_W-1:0]       acc_raddr;
    logic [0:0][DATA_W-1:0]       acc_rdata;
    logic                         mark_en, use_en, multi_if, spare_empty, rb_take;
    logic [DIE_W:0]               nxt_die;

    function automatic logic [DIE_W:0] next_survivor(input logic [DIE_W-1:0] from,
                                                     input logic [DIE_W-1:0] skip);
        logic [DIE_W:0] n;
        n = {1'b0, from} + (DIE_W+1)'(1);
        if (n < DIE_END && n[DIE_W-1:0] == skip) n = n + (DIE_W+1)'(1);
        return n;
    endfunction

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        par_we    = 1'b0;
        par_xor   = (r_q.wr_die != '0);
        acc_we    = 1'b0;
        acc_xor   = !r_q.first;
        acc_wdata = r_q.first ? (par_rdata[1] ^ in_data) : in_data;
        mark_en   = 1'b0;
        use_en    = 1'b0;
        nxt_die   = next_survivor(r_q.cur_die, r_q.rb_die);
        rb_ready  = (r_q.st == XS_IDLE) && r_q.par_valid;
        rb_take   = rb_valid && rb_ready;

        unique case (r_q.st)
            XS_IDLE: begin
                if (rb_take) begin
                    mark_en       = 1'b1;
                    r_d.done      = 1'b0;
                    r_d.err_multi = 1'b0;
                    r_d.err_nospare = 1'b0;
                    if (multi_if) begin
                        r_d.err_multi = 1'b1;
                    end else if (spare_empty) begin
                        r_d.err_nospare = 1'b1;
                    end else begin
                        r_d.st      = XS_GATHER;
                        r_d.rb_die  = rb_die;
                        r_d.cur_die = (rb_die == '0) ? DIE_W'(1) : '0;
                        r_d.beat    = '0;
                        r_d.first   = 1'b1;
                    end
                end else begin
                    in_ready = (in_die == r_q.wr_die);
                    if (in_valid && in_ready) begin
                        par_we = 1'b1;
                        if (r_q.wr_die == '0 && r_q.wr_beat == '0) r_d.par_valid = 1'b0;
                        r_d.wr_beat = r_q.wr_beat + BEAT_W'(1);
                        if (r_q.wr_beat == LAST_BEAT) begin
                            r_d.wr_beat = '0;
                            if (r_q.wr_die == LAST_DIE) begin
                                r_d.wr_die    = '0;
                                r_d.par_valid = 1'b1;
                            end else begin
                                r_d.wr_die = r_q.wr_die + DIE_W'(1);
                            end
                        end
                    end
                end
            end
            XS_GATHER: begin
                in_ready = (in_die == r_q.cur_die);
                if (in_valid && in_ready) begin
                    acc_we   = 1'b1;
                    r_d.beat = r_q.beat + BEAT_W'(1);
                    if (r_q.beat == LAST_BEAT) begin
                        r_d.beat  = '0;
                        r_d.first = 1'b0;
                        if (nxt_die >= DIE_END) r_d.st = XS_EMIT;
                        else r_d.cur_die = nxt_die[DIE_W-1:0];
                    end
                end
            end
            XS_EMIT: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    r_d.beat = r_q.beat + BEAT_W'(1);
                    if (r_q.beat == LAST_BEAT) begin
                        r_d.beat = '0;
                        r_d.st   = XS_IDLE;
                        r_d.done = 1'b1;
                        use_en   = 1'b1;
                    end
                end
            end
            default: r_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: XS_IDLE, wr_die: '0, wr_beat: '0, par_valid: 1'b0,
                     rb_die: '0, cur_die: '0, beat: '0, first: 1'b0,
                     done: 1'b0, err_multi: 1'b0, err_nospare: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign par_raddr[0] = par_rd_beat;
    assign par_raddr[1] = r_q.beat;
    assign acc_raddr[0] = r_q.beat;

    xpr_page_buf #(.DATA_W(DATA_W), .DEPTH(PAGE_BEATS), .N_RD(2)) u_parity (
        .clk(clk), .rst_n(rst_n), .wr_en(par_we), .wr_xor(par_xor),
        .wr_addr(r_q.wr_beat), .wr_data(in_data),
        .rd_addr(par_raddr), .rd_data(par_rdata)
    );

    xpr_page_buf #(.DATA_W(DATA_W), .DEPTH(PAGE_BEATS), .N_RD(1)) u_accum (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_we), .wr_xor(acc_xor),
        .wr_addr(r_q.beat), .wr_data(acc_wdata),
        .rd_addr(acc_raddr), .rd_data(acc_rdata)
    );

    xpr_fail_track #(.NUM_DIES(NUM_DIES), .SPARE_SLOTS(SPARE_SLOTS)) u_track (
        .clk(clk), .rst_n(rst_n), .mark_en(mark_en), .q_die(rb_die),
        .use_en(use_en), .failed(failed_map), .spare_left(spare_left),
        .multi_if(multi_if), .spare_empty(spare_empty)
    );

    assign need_die    = (r_q.st == XS_GATHER) ? r_q.cur_die : r_q.wr_die;
    assign out_data    = acc_rdata[0];
    assign out_beat    = r_q.beat;
    assign out_last    = (r_q.st == XS_EMIT) && (r_q.beat == LAST_BEAT);
    assign par_valid   = r_q.par_valid;
    assign par_rd_data = par_rdata[0];
    assign done        = r_q.done;
    assign err_multi   = r_q.err_multi;
    assign err_nospare = r_q.err_nospare;

    // R6: a stalled rebuilt beat holds
    assert_emit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_beat) && $stable(out_data)));

    // R5: the failed die is never taken as a survivor
    assert_skip_failed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == XS_GATHER && in_valid && in_ready) |-> (in_die != r_q.rb_die));

    // R9: refusal on multiple failures emits nothing and spends nothing
    assert_multi_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_valid && rb_ready && multi_if) |=>
        (err_multi && !out_valid && spare_left == $past(spare_left)));

    // R10: refusal on empty spare emits nothing
    assert_nospare_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_valid && rb_ready && !multi_if && spare_empty) |=> (err_nospare && !out_valid));

    // R7: each completed rebuild spends exactly one slot
    assert_done_spends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (spare_left == $past(spare_left) - SPARE_W'(1)));
endmodule

// File: tb/xor_rebuild_engine_test.sv
module xor_rebuild_engine_test;
    localparam int N  = 8;
    localparam int PB = 16;
    localparam int DW = 32;
    localparam int SP = 2;
    localparam int DIE_W   = $clog2(N);
    localparam int BEAT_W  = $clog2(PB);
    localparam int SPARE_W = $clog2(SP + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b0, rb_valid = 1'b0;
    logic [DIE_W-1:0]  in_die = '0, rb_die = '0;
    logic [DW-1:0]     in_data = '0;
    logic [BEAT_W-1:0] par_rd_beat = '0;
    logic in_ready, rb_ready, out_valid, out_last, par_valid, done, err_multi, err_nospare;
    logic [DIE_W-1:0]   need_die;
    logic [DW-1:0]      out_data, par_rd_data;
    logic [BEAT_W-1:0]  out_beat;
    logic [N-1:0]       failed_map;
    logic [SPARE_W-1:0] spare_left;

    xor_rebuild_engine #(.NUM_DIES(N), .PAGE_BEATS(PB), .DATA_W(DW), .SPARE_SLOTS(SP)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_die(in_die), .in_data(in_data), .need_die(need_die),
        .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_die(rb_die),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_beat(out_beat), .out_last(out_last), .par_valid(par_valid),
        .par_rd_beat(par_rd_beat), .par_rd_data(par_rd_data),
        .failed_map(failed_map), .spare_left(spare_left), .done(done),
        .err_multi(err_multi), .err_nospare(err_nospare)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;
    logic [DW-1:0] page [N][PB];
    logic [N-1:0]  m_failed = '0;
    int            m_spare = SP;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model compared on every clock while out of reset
    always @(negedge clk) begin
        if (rst_n) begin
            check(failed_map == m_failed, "R8 failed map", DW'(failed_map), DW'(m_failed));
            check(int'(spare_left) == m_spare, "R7 spare count", DW'(spare_left), DW'(m_spare));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        m_failed = '0;
        m_spare = SP;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_beat(input int die, input logic [DW-1:0] data);
        @(negedge clk);
        in_valid = 1'b1; in_die = DIE_W'(die); in_data = data;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic write_stripe(input int seed);
        for (int d = 0; d < N; d++) begin
            for (int b = 0; b < PB; b++) begin
                page[d][b] = DW'(seed * 32'h9E3779B1) ^ DW'(d * 32'h01030507) ^ DW'(b * 32'h00110011);
                send_beat(d, page[d][b]);
                if (d == 0 && b == 0)
                    check(par_valid == 1'b0, "R2 parity valid drops on new stripe", DW'(par_valid), 0);
            end
        end
        @(negedge clk);
        check(par_valid == 1'b1, "R1 parity valid after stripe", DW'(par_valid), 1);
    endtask

    task automatic check_parity(input string tag);
        for (int b = 0; b < PB; b++) begin
            logic [DW-1:0] x;
            x = '0;
            for (int d = 0; d < N; d++) x = x ^ page[d][b];
            par_rd_beat = BEAT_W'(b);
            #1;
            check(par_rd_data == x, tag, par_rd_data, x);
        end
    endtask

    task automatic rebuild(input int die, input int stall_mod);
        int pc;
        @(negedge clk);
        rb_valid = 1'b1; rb_die = DIE_W'(die);
        #1;
        while (!rb_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        rb_valid = 1'b0;
        m_failed[die] = 1'b1;
        pc = $countones(m_failed);
        if (pc >= 2) begin
            @(negedge clk);
            check(err_multi == 1'b1, "R9 multi failure flagged", DW'(err_multi), 1);
            check(err_nospare == 1'b0, "R12 multi has priority", DW'(err_nospare), 0);
            check(done == 1'b0, "R12 done cleared", DW'(done), 0);
            check(out_valid == 1'b0, "R9 no output", DW'(out_valid), 0);
            check(need_die == '0, "R9 stays on write stream", DW'(need_die), 0);
        end else if (m_spare == 0) begin
            @(negedge clk);
            check(err_nospare == 1'b1, "R10 spare exhausted flagged", DW'(err_nospare), 1);
            check(done == 1'b0, "R12 done cleared", DW'(done), 0);
            check(out_valid == 1'b0, "R10 no output", DW'(out_valid), 0);
        end else begin
            for (int d = 0; d < N; d++) begin
                if (d != die) begin
                    check(int'(need_die) == d, "R5 survivor order", DW'(need_die), DW'(d));
                    for (int b = 0; b < PB; b++) send_beat(d, page[d][b]);
                end
            end
            for (int b = 0; b < PB; b++) begin
                @(negedge clk);
                if (b % stall_mod == 1) begin
                    out_ready = 1'b0;
                    @(negedge clk);
                    check(out_valid == 1'b1 && int'(out_beat) == b, "R6 hold under stall",
                          DW'(out_beat), DW'(b));
                end
                out_ready = 1'b1;
                #1;
                while (!out_valid) begin @(negedge clk); #1; end
                check(out_data == page[die][b], "R6 rebuilt data", out_data, page[die][b]);
                check(int'(out_beat) == b, "R6 beat order", DW'(out_beat), DW'(b));
                check(out_last == (b == PB - 1), "R6 last marker", DW'(out_last), DW'(b == PB - 1));
                @(posedge clk); #1;
                out_ready = 1'b0;
                if (b == PB - 1) m_spare--;
            end
            @(negedge clk);
            check(done == 1'b1, "R7 done after rebuild", DW'(done), 1);
            check(err_multi == 1'b0 && err_nospare == 1'b0, "R12 errors clear on success",
                  DW'({err_multi, err_nospare}), 0);
            check(out_valid == 1'b0, "R6 output ends", DW'(out_valid), 0);
        end
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check(par_valid == 1'b0, "R11 parity not valid", DW'(par_valid), 0);
        check(failed_map == '0, "R11 no failures", DW'(failed_map), 0);
        check(int'(spare_left) == SP, "R11 full spare", DW'(spare_left), DW'(SP));
        check({done, err_multi, err_nospare, out_valid} == 4'b0, "R11 flags clear",
              DW'({done, err_multi, err_nospare, out_valid}), 0);
        check(need_die == '0, "R11 first die expected", DW'(need_die), 0);

        // R4: request before parity exists is held off
        rb_valid = 1'b1; rb_die = DIE_W'(2);
        repeat (3) begin
            #1;
            check(rb_ready == 1'b0, "R4 refused without parity", DW'(rb_ready), 0);
            @(negedge clk);
        end
        rb_valid = 1'b0;
        check(failed_map == '0 && err_multi == 1'b0 && err_nospare == 1'b0,
              "R4 nothing recorded", DW'(failed_map), 0);

        write_stripe(1);
        check_parity("R1 parity contents");

        // R3: a beat for the wrong die is not taken
        @(negedge clk);
        in_valid = 1'b1; in_die = DIE_W'(3); in_data = 32'hDEADBEEF;
        repeat (3) begin
            #1;
            check(in_ready == 1'b0, "R3 wrong die held off", DW'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(par_valid == 1'b1 && need_die == '0, "R3 sequence untouched", DW'(need_die), 0);
        check_parity("R3 parity untouched");

        rebuild(5, 3);
        write_stripe(2);
        check_parity("R2 parity of new stripe only");
        rebuild(5, 4);
        rebuild(5, 3);
        rebuild(2, 3);

        do_reset();
        write_stripe(3);
        rebuild(0, 3);

        do_reset();
        write_stripe(4);
        check_parity("R1 parity contents, second pattern");
        rebuild(N - 1, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule